// File: doc/BRIEF.md
# Display Interrupt Status Unit

This block collects the interrupt sources of a multi-channel display controller into two sticky status words and turns them into one level-sensitive interrupt line. Channel 0 is the base plane. Its frame and branch events share the first status word with a set of controller-wide events: disable done, quick disable, underruns, read status, command and AC-bias count. Channels 1 and up report start-of-frame, end-of-frame and branch events in the second status word. Each source that can drive the line has a mask bit, and a set mask bit silences that source.

Every per-channel event carries a frame identifier. When an unmasked per-channel event arrives while the line is low, the identifier is copied into an identification register, which software reads to learn which frame raised the interrupt. If the line is already high, a second-interrupt flag is set and the identifier is left alone. A bus error always counts as unmasked and also records its channel number in a 3-bit field.

Software reaches the block through a small register port. Control writes are filtered by write masks. Status writes clear the bits written as one. Clearing the enable bit in the main control word produces a quick-disable event.

Top module: `disp_irq_status`

## Requirements
- R1: After reset, all five registers read 0 and `irq_o` is low.
- R2: Status word 0 bit positions are fixed, because software decodes them. Disable done sets bit 0. Channel 0 start-of-frame sets bit 1, bus error sets bit 2 and AC-bias count sets bit 3. Underrun of channel 0 sets bit 4 and of channel 1 sets bit 5. Output underrun sets bit 6 and quick disable sets bit 7. Channel 0 end-of-frame sets bit 8 and channel 0 branch sets bit 9. Second interrupt is bit 10, read status is bit 11 and command is bit 12.
- R3: For channel n (1 and up), status word 1 holds start-of-frame at bit n-1, end-of-frame at bit n+7 and branch at bit n+15.
- R4: A bus error on channel c sets status 0 bit 2 and ORs c into status 0 bits 30:28. Bus errors on several channels accumulate in that field.
- R5: `irq_o` is registered and reflects the state of the previous cycle. It is high when any status 0 bit in {0,1,4,6,7,8,9,11,12} is set with control 0 bit (16+k) clear, or when status 0 bit 5 is set with control 5 bit 24 clear, or when any status 1 bit is set with the same bit of control 5 clear. Status 0 bits 2, 3 and 10 never drive the line.
- R6: Register select values: 0 is control 0, 1 is control 5, 2 is status 0, 3 is status 1 and 4 is identification. Control 0 keeps only the bits in 0x1BD30001, where bit 0 is enable. Control 5 keeps only the bits in 0x3F3F3F3F. Writes to the identification register have no effect. Any other select value reads 0.
- R7: An unmasked per-channel event that arrives while `irq_o` is low copies that channel's frame ID into the identification register. If several unmasked events arrive in one cycle, the lowest channel index wins. Masked events capture nothing. The masks for channel 0 are control 0 bits 17, 24 and 25. For channel n the masks sit in control 5 at the status 1 positions.
- R8: An unmasked per-channel event that arrives while `irq_o` is high sets status 0 bit 10 and leaves the identification register unchanged.
- R9: A bus error is unmasked whatever the mask settings.
- R10: Writing status 0 clears the written ones in bits 11:0. When bit 2 is written as one, bits 30:28 are also cleared. Bit 12 is not cleared by writes.
- R11: Writing status 1 clears the written ones only within 0x003E3F3F. The channel 1 branch bit (bit 16) is kept.
- R12: Writing control 0 with bit 0 clear while it was set sets status 0 bit 7. Writing it clear while it is already clear does not.
- R13: When an event and a clearing write hit the same status bit in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| reg_wr_i | input | 1 | register write strobe |
| reg_sel_i | input | 3 | register select |
| reg_wdata_i | input | 32 | write data |
| reg_rdata_o | output | 32 | read data of the selected register |
| ev_sof_i | input | NUM_CH | start-of-frame pulse per channel |
| ev_eof_i | input | NUM_CH | end-of-frame pulse per channel |
| ev_brs_i | input | NUM_CH | branch-status pulse per channel |
| ev_buserr_i | input | NUM_CH | bus-error pulse per channel |
| ev_fid_i | input | NUM_CH*ID_W | frame ID per channel, channel c at bits c*ID_W upward |
| ev_done_i | input | 1 | disable-done pulse |
| ev_acbias_i | input | 1 | AC-bias count pulse |
| ev_under_i | input | 2 | underrun pulse for channels 0 and 1 |
| ev_outunder_i | input | 1 | output underrun pulse |
| ev_rdstat_i | input | 1 | read-status pulse |
| ev_cmd_i | input | 1 | command interrupt pulse |
| irq_o | output | 1 | registered interrupt level |

## Verification
Two kinds of collision can fall in one cycle. The first is an event and a write-1-to-clear on the same status word. The second is an event that arrives on the cycle the registered line has just risen, so whether the frame ID is captured or the second-interrupt flag is set depends on the one-cycle lag. The bench provokes both on purpose: it pulses disable-done and a bus error on the cycle of a clearing write, and it fires a branch event while the line is high. A random phase then overlaps events, mask writes and clears freely. A behavioural model decides each cycle's outcome from the requirements and is compared against the line and the selected register on every clock.

// File: rtl/disp_irq_pkg.sv
`timescale 1ns/1ps
package disp_irq_pkg;
   localparam int REG_W = 32;

   // status word 0 bit positions (decoded by software)
   localparam int B_DONE    = 0;
   localparam int B_SOF0    = 1;
   localparam int B_BUSERR  = 2;
   localparam int B_ACBIAS  = 3;
   localparam int B_UND0    = 4;
   localparam int B_UND1    = 5;
   localparam int B_OUTUND  = 6;
   localparam int B_QDIS    = 7;
   localparam int B_EOF0    = 8;
   localparam int B_BRS0    = 9;
   localparam int B_SINT    = 10;
   localparam int B_RDSTAT  = 11;
   localparam int B_CMD     = 12;
   localparam int BERCH_LSB = 28;
   localparam int BERCH_W   = 3;

   // control 0: bit 0 enable, mask for status 0 bit k at bit k+MASK_OFS
   localparam int MASK_OFS      = 16;
   localparam int UND1_MASK_BIT = 24;   // lives in control 5
   localparam logic [REG_W-1:0] S0_LINE_SRC = 32'h0000_1BD3;
   localparam logic [REG_W-1:0] CTL0_WMASK  = (S0_LINE_SRC << MASK_OFS) | 32'h1;
   localparam logic [REG_W-1:0] CTL5_WMASK  = 32'h3F3F_3F3F;
   localparam logic [REG_W-1:0] S0_CLRMASK  = 32'h0000_0FFF;
   localparam logic [REG_W-1:0] S1_CLRMASK  = 32'h003E_3F3F;
   localparam logic [REG_W-1:0] BERCH_FIELD = 32'h7000_0000;

   // status word 1 offsets relative to channel number
   localparam int S1_SOF_OFS = -1;
   localparam int S1_EOF_OFS = 7;
   localparam int S1_BRS_OFS = 15;

   typedef enum logic [2:0] {
      SEL_CTL0  = 3'd0,
      SEL_CTL5  = 3'd1,
      SEL_STAT0 = 3'd2,
      SEL_STAT1 = 3'd3,
      SEL_IDENT = 3'd4
   } reg_sel_e;
endpackage

// File: rtl/disp_irq_chan_evt.sv
`timescale 1ns/1ps
module disp_irq_chan_evt
   import disp_irq_pkg::*;
#(
   parameter int CH = 0
)(
   input  logic             sof_i,
   input  logic             eof_i,
   input  logic             brs_i,
   input  logic             ber_i,
   input  logic [2:0]       msk_i,    // {brs, eof, sof}, 1 = masked
   output logic [REG_W-1:0] set0_o,
   output logic [REG_W-1:0] set1_o,
   output logic             hit_o
);
   // bus error counts as unmasked for capture purposes
   assign hit_o = (sof_i & ~msk_i[0]) | (eof_i & ~msk_i[1]) |
                  (brs_i & ~msk_i[2]) | ber_i;

   generate
      if (CH == 0) begin : g_base
         always_comb begin
            set0_o           = '0;
            set0_o[B_SOF0]   = sof_i;
            set0_o[B_EOF0]   = eof_i;
            set0_o[B_BRS0]   = brs_i;
            set0_o[B_BUSERR] = ber_i;
            set1_o           = '0;
         end
      end else begin : g_side
         localparam int SB = CH + S1_SOF_OFS;
         localparam int EB = CH + S1_EOF_OFS;
         localparam int BB = CH + S1_BRS_OFS;
         always_comb begin
            set0_o           = '0;
            set0_o[B_BUSERR] = ber_i;
            set1_o           = '0;
            set1_o[SB]       = sof_i;
            set1_o[EB]       = eof_i;
            set1_o[BB]       = brs_i;
         end
      end
   endgenerate
endmodule

// File: rtl/disp_irq_id_pick.sv
`timescale 1ns/1ps
module disp_irq_id_pick #(
   parameter int NUM_CH = 7,
   parameter int ID_W   = 32
)(
   input  logic [NUM_CH-1:0]      hit_i,
   input  logic [NUM_CH*ID_W-1:0] fid_i,
   input  logic                   line_i,
   output logic                   cap_o,
   output logic [ID_W-1:0]        id_o,
   output logic                   sint_o
);
   logic any_hit;
   assign any_hit = |hit_i;
   assign cap_o   = any_hit & ~line_i;
   assign sint_o  = any_hit & line_i;

   // walk downwards so the lowest active channel is the last to write
   always_comb begin
      id_o = '0;
      for (int c = NUM_CH - 1; c >= 0; c--) begin
         if (hit_i[c]) id_o = fid_i[c*ID_W +: ID_W];
      end
   end
endmodule

// File: rtl/disp_irq_line.sv
`timescale 1ns/1ps
module disp_irq_line
   import disp_irq_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [REG_W-1:0] stat0_i,
   input  logic [REG_W-1:0] stat1_i,
   input  logic [REG_W-1:0] ctl0_i,
   input  logic [REG_W-1:0] ctl5_i,
   output logic             irq_o
);
   logic base_act, und1_act, side_act, line_d;

   assign base_act = |(stat0_i & S0_LINE_SRC & ~(ctl0_i >> MASK_OFS));
   assign und1_act = stat0_i[B_UND1] & ~ctl5_i[UND1_MASK_BIT];
   assign side_act = |(stat1_i & ~ctl5_i);
   assign line_d   = base_act | und1_act | side_act;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_o <= 1'b0;
      else         irq_o <= line_d;
   end
endmodule

// File: rtl/disp_irq_status.sv
`timescale 1ns/1ps
module disp_irq_status
   import disp_irq_pkg::*;
#(
   parameter int NUM_CH = 7,
   parameter int ID_W   = 32
)(
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   reg_wr_i,
   input  logic [2:0]             reg_sel_i,
   input  logic [REG_W-1:0]       reg_wdata_i,
   output logic [REG_W-1:0]       reg_rdata_o,
   input  logic [NUM_CH-1:0]      ev_sof_i,
   input  logic [NUM_CH-1:0]      ev_eof_i,
   input  logic [NUM_CH-1:0]      ev_brs_i,
   input  logic [NUM_CH-1:0]      ev_buserr_i,
   input  logic [NUM_CH*ID_W-1:0] ev_fid_i,
   input  logic                   ev_done_i,
   input  logic                   ev_acbias_i,
   input  logic [1:0]             ev_under_i,
   input  logic                   ev_outunder_i,
   input  logic                   ev_rdstat_i,
   input  logic                   ev_cmd_i,
   output logic                   irq_o
);
   localparam int FID_W = NUM_CH * ID_W;

   if (NUM_CH < 2 || NUM_CH > 7) begin : g_bad_ch
      $error("disp_irq_status: NUM_CH must be 2..7");
   end
   if (ID_W < 1 || ID_W > REG_W) begin : g_bad_id
      $error("disp_irq_status: ID_W must be 1..32");
   end

   logic [REG_W-1:0] ctl0_q, ctl5_q, stat0_q, stat1_q, ident_q;
   logic [REG_W-1:0] stat0_d, stat1_d, evt0, evt1, clr0, clr1;
   logic [REG_W-1:0] ch_set0 [NUM_CH];
   logic [REG_W-1:0] ch_set1 [NUM_CH];
   logic [NUM_CH-1:0] ch_hit;
   logic [BERCH_W-1:0] berch;
   logic              id_cap, sint_set;
   logic [ID_W-1:0]   id_new;
   logic              wr_ctl0, wr_ctl5, wr_s0, wr_s1, qdis_set;

   // per-channel event decode; the mask source differs for the base plane
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [2:0] msk;
      if (c == 0) begin : g_m0
         assign msk = {ctl0_q[B_BRS0 + MASK_OFS], ctl0_q[B_EOF0 + MASK_OFS],
                       ctl0_q[B_SOF0 + MASK_OFS]};
      end else begin : g_mn
         assign msk = {ctl5_q[c + S1_BRS_OFS], ctl5_q[c + S1_EOF_OFS],
                       ctl5_q[c + S1_SOF_OFS]};
      end
      disp_irq_chan_evt #(.CH(c)) u_evt (
         .sof_i  (ev_sof_i[c]),
         .eof_i  (ev_eof_i[c]),
         .brs_i  (ev_brs_i[c]),
         .ber_i  (ev_buserr_i[c]),
         .msk_i  (msk),
         .set0_o (ch_set0[c]),
         .set1_o (ch_set1[c]),
         .hit_o  (ch_hit[c])
      );
   end

   disp_irq_id_pick #(.NUM_CH(NUM_CH), .ID_W(ID_W)) u_pick (
      .hit_i  (ch_hit),
      .fid_i  (ev_fid_i[FID_W-1:0]),
      .line_i (irq_o),
      .cap_o  (id_cap),
      .id_o   (id_new),
      .sint_o (sint_set)
   );

   disp_irq_line u_line (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .stat0_i (stat0_q),
      .stat1_i (stat1_q),
      .ctl0_i  (ctl0_q),
      .ctl5_i  (ctl5_q),
      .irq_o   (irq_o)
   );

   assign wr_ctl0  = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_CTL0);
   assign wr_ctl5  = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_CTL5);
   assign wr_s0    = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_STAT0);
   assign wr_s1    = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_STAT1);
   assign qdis_set = wr_ctl0 && ctl0_q[0] && !reg_wdata_i[0];

   always_comb begin
      evt0  = '0;
      evt1  = '0;
      berch = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         evt0 = evt0 | ch_set0[c];
         evt1 = evt1 | ch_set1[c];
         if (ev_buserr_i[c]) berch = berch | BERCH_W'(c);
      end
      evt0[B_DONE]   = ev_done_i;
      evt0[B_ACBIAS] = ev_acbias_i;
      evt0[B_UND0]   = ev_under_i[0];
      evt0[B_UND1]   = ev_under_i[1];
      evt0[B_OUTUND] = ev_outunder_i;
      evt0[B_RDSTAT] = ev_rdstat_i;
      evt0[B_CMD]    = ev_cmd_i;
      evt0[B_QDIS]   = qdis_set;
      evt0[B_SINT]   = sint_set;
      evt0[BERCH_LSB +: BERCH_W] = berch;
   end

   always_comb begin
      clr0 = '0;
      clr1 = '0;
      if (wr_s0) begin
         clr0 = reg_wdata_i & S0_CLRMASK;
         if (reg_wdata_i[B_BUSERR]) clr0 = clr0 | BERCH_FIELD;
      end
      if (wr_s1) clr1 = reg_wdata_i & S1_CLRMASK;
      // a new event outranks a same-cycle clear
      stat0_d = (stat0_q & ~clr0) | evt0;
      stat1_d = (stat1_q & ~clr1) | evt1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctl0_q  <= '0;
         ctl5_q  <= '0;
         stat0_q <= '0;
         stat1_q <= '0;
         ident_q <= '0;
      end else begin
         if (wr_ctl0) ctl0_q <= reg_wdata_i & CTL0_WMASK;
         if (wr_ctl5) ctl5_q <= reg_wdata_i & CTL5_WMASK;
         stat0_q <= stat0_d;
         stat1_q <= stat1_d;
         if (id_cap) ident_q <= REG_W'(id_new);
      end
   end

   always_comb begin
      unique case (reg_sel_i)
         SEL_CTL0:  reg_rdata_o = ctl0_q;
         SEL_CTL5:  reg_rdata_o = ctl5_q;
         SEL_STAT0: reg_rdata_o = stat0_q;
         SEL_STAT1: reg_rdata_o = stat1_q;
         SEL_IDENT: reg_rdata_o = ident_q;
         default:   reg_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/disp_irq_status_chk.sv
`timescale 1ns/1ps
module disp_irq_status_chk
   import disp_irq_pkg::*;
#(
   parameter int NUM_CH = 7,
   parameter int ID_W   = 32
)(
   input logic                   clk_i,
   input logic                   rst_ni,
   input logic                   irq_o,
   input logic                   reg_wr_i,
   input logic [2:0]             reg_sel_i,
   input logic [REG_W-1:0]       reg_wdata_i,
   input logic [NUM_CH-1:0]      ev_buserr_i,
   input logic [NUM_CH*ID_W-1:0] ev_fid_i,
   input logic                   ev_done_i,
   input logic [REG_W-1:0]       ctl0_q,
   input logic [REG_W-1:0]       stat0_q,
   input logic [REG_W-1:0]       stat1_q,
   input logic [REG_W-1:0]       ident_q
);
   localparam logic [BERCH_W-1:0] TOP_CH = BERCH_W'(NUM_CH - 1);

   p_ber_field_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_buserr_i[NUM_CH-1] |=> stat0_q[B_BUSERR] &&
         ((stat0_q[BERCH_LSB +: BERCH_W] & TOP_CH) == TOP_CH));

   p_quiet_line_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat0_q == '0 && stat1_q == '0) |=> !irq_o);

   p_ber_capture_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!irq_o && ev_buserr_i[0]) |=> ident_q[ID_W-1:0] == $past(ev_fid_i[ID_W-1:0]));

   p_second_int_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && |ev_buserr_i) |=> stat0_q[B_SINT]);

   p_ident_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |=> $stable(ident_q));

   p_keep_brs1_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat1_q[16] |=> stat1_q[16]);

   p_quick_dis_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_wr_i && reg_sel_i == SEL_CTL0 && ctl0_q[0] && !reg_wdata_i[0])
         |=> stat0_q[B_QDIS]);

   p_set_wins_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_done_i |=> stat0_q[B_DONE]);
endmodule

bind disp_irq_status disp_irq_status_chk #(.NUM_CH(NUM_CH), .ID_W(ID_W)) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .irq_o       (irq_o),
   .reg_wr_i    (reg_wr_i),
   .reg_sel_i   (reg_sel_i),
   .reg_wdata_i (reg_wdata_i),
   .ev_buserr_i (ev_buserr_i),
   .ev_fid_i    (ev_fid_i),
   .ev_done_i   (ev_done_i),
   .ctl0_q      (ctl0_q),
   .stat0_q     (stat0_q),
   .stat1_q     (stat1_q),
   .ident_q     (ident_q)
);

// File: tb/disp_irq_status_tb_top.sv
`timescale 1ns/1ps
module disp_irq_status_tb_top;
   localparam int NCH = 7;
   localparam int IDW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic            reg_wr = 1'b0;
   logic [2:0]      reg_sel = 3'd0;
   logic [31:0]     reg_wdata = '0;
   logic [31:0]     reg_rdata;
   logic [NCH-1:0]  sof = '0, eof = '0, brs = '0, ber = '0;
   logic [IDW-1:0]  fid [NCH];
   logic [NCH*IDW-1:0] fid_flat;
   logic            done = 1'b0, acb = 1'b0, outund = 1'b0, rdst = 1'b0, cmd = 1'b0;
   logic [1:0]      und = '0;
   logic            irq;

   always_comb begin
      for (int c = 0; c < NCH; c++) fid_flat[c*IDW +: IDW] = fid[c];
   end

   disp_irq_status #(.NUM_CH(NCH), .ID_W(IDW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
      .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
      .ev_sof_i(sof), .ev_eof_i(eof), .ev_brs_i(brs), .ev_buserr_i(ber),
      .ev_fid_i(fid_flat), .ev_done_i(done), .ev_acbias_i(acb),
      .ev_under_i(und), .ev_outunder_i(outund), .ev_rdstat_i(rdst),
      .ev_cmd_i(cmd), .irq_o(irq));

   int n_vec = 0;
   int n_bad = 0;

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_c0, m_c5, m_s0, m_s1, m_id;
   logic        m_irq;

   function automatic logic [31:0] m_read(input logic [2:0] s);
      case (s)
         3'd0: return m_c0;
         3'd1: return m_c5;
         3'd2: return m_s0;
         3'd3: return m_s1;
         3'd4: return m_id;
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_c0 = 0; m_c5 = 0; m_s0 = 0; m_s1 = 0; m_id = 0; m_irq = 0;
      end else begin
         logic [31:0] set0, set1, clr0, clr1;
         logic        nxt_irq, found, ms, me, mb, h;
         logic [31:0] pick;
         nxt_irq = 1'b0;
         for (int k = 0; k < 13; k++)
            if (k != 2 && k != 3 && k != 5 && k != 10 && m_s0[k] && !m_c0[k+16]) nxt_irq = 1'b1;
         if (m_s0[5] && !m_c5[24]) nxt_irq = 1'b1;
         for (int k = 0; k < 32; k++) if (m_s1[k] && !m_c5[k]) nxt_irq = 1'b1;
         set0 = 0; set1 = 0; clr0 = 0; clr1 = 0; found = 0; pick = 0;
         for (int c = 0; c < NCH; c++) begin
            if (c == 0) begin
               ms = m_c0[17]; me = m_c0[24]; mb = m_c0[25];
               if (sof[0]) set0[1] = 1'b1;
               if (eof[0]) set0[8] = 1'b1;
               if (brs[0]) set0[9] = 1'b1;
            end else begin
               ms = m_c5[c-1]; me = m_c5[c+7]; mb = m_c5[c+15];
               if (sof[c]) set1[c-1]  = 1'b1;
               if (eof[c]) set1[c+7]  = 1'b1;
               if (brs[c]) set1[c+15] = 1'b1;
            end
            if (ber[c]) begin
               set0[2] = 1'b1;
               set0[30:28] = set0[30:28] | 3'(c);
            end
            h = (sof[c] && !ms) || (eof[c] && !me) || (brs[c] && !mb) || ber[c];
            if (h && !found) begin found = 1'b1; pick = fid[c]; end
         end
         if (done) set0[0] = 1'b1;
         if (acb) set0[3] = 1'b1;
         if (und[0]) set0[4] = 1'b1;
         if (und[1]) set0[5] = 1'b1;
         if (outund) set0[6] = 1'b1;
         if (rdst) set0[11] = 1'b1;
         if (cmd) set0[12] = 1'b1;
         if (found) begin
            if (m_irq) set0[10] = 1'b1;
            else m_id = pick;
         end
         if (reg_wr) begin
            case (reg_sel)
               3'd0: begin
                  if (m_c0[0] && !reg_wdata[0]) set0[7] = 1'b1;
                  m_c0 = reg_wdata & 32'h1BD3_0001;
               end
               3'd1: m_c5 = reg_wdata & 32'h3F3F_3F3F;
               3'd2: begin
                  clr0 = reg_wdata & 32'hFFF;
                  if (reg_wdata[2]) clr0[30:28] = 3'b111;
               end
               3'd3: clr1 = reg_wdata & 32'h003E_3F3F;
               default: ;
            endcase
         end
         m_s0 = (m_s0 & ~clr0) | set0;
         m_s1 = (m_s1 & ~clr1) | set1;
         m_irq = nxt_irq;
      end
   end

   // every-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         n_vec++;
         if (irq !== m_irq) begin
            n_bad++;
            $display("FAIL R5 irq line t=%0t actual %0b expected %0b", $time, irq, m_irq);
         end
         n_vec++;
         if (reg_rdata !== m_read(reg_sel)) begin
            n_bad++;
            $display("FAIL R6 readback sel %0d actual %h expected %h", reg_sel, reg_rdata, m_read(reg_sel));
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic clr_ev();
      sof = '0; eof = '0; brs = '0; ber = '0;
      done = 0; acb = 0; und = '0; outund = 0; rdst = 0; cmd = 0;
   endtask

   task automatic wr(input logic [2:0] s, input logic [31:0] d);
      reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
      step();
      reg_wr = 1'b0;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] s, input logic [31:0] exp, input logic [31:0] msk, input string tag);
      reg_sel = s;
      @(negedge clk);
      chk(tag, reg_rdata & msk, exp & msk);
      step();
   endtask

   task automatic irq_is(input logic exp, input string tag);
      @(negedge clk);
      chk(tag, {31'h0, irq}, {31'h0, exp});
      step();
   endtask

   localparam logic [31:0] ALL = 32'hFFFF_FFFF;
   logic done_flag = 1'b0;

   initial begin
      for (int c = 0; c < NCH; c++) fid[c] = 32'h100 + c;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      // R1 reset state
      rd(3'd0, 0, ALL, "R1 ctl0"); rd(3'd1, 0, ALL, "R1 ctl5");
      rd(3'd2, 0, ALL, "R1 stat0"); rd(3'd3, 0, ALL, "R1 stat1");
      rd(3'd4, 0, ALL, "R1 ident"); irq_is(1'b0, "R1 irq");
      // R6 write masks, read-only ident, unused select
      wr(3'd0, ALL); rd(3'd0, 32'h1BD3_0001, ALL, "R6 ctl0 mask");
      wr(3'd1, ALL); rd(3'd1, 32'h3F3F_3F3F, ALL, "R6 ctl5 mask");
      wr(3'd4, 32'h1234); rd(3'd4, 0, ALL, "R6 ident read-only");
      rd(3'd6, 0, ALL, "R6 unused select");
      // R2 / R7: masked SOF0 sets bit 1, captures nothing
      fid[0] = 32'hA0; sof[0] = 1; step(); clr_ev();
      rd(3'd2, 32'h2, ALL, "R2 sof0 bit");
      rd(3'd4, 0, ALL, "R7 masked no capture");
      irq_is(1'b0, "R5 masked source");
      // R9 / R4: bus error with every mask set
      fid[3] = 32'h33; ber[3] = 1; step(); clr_ev();
      rd(3'd4, 32'h33, ALL, "R9 ber unmasked");
      rd(3'd2, 32'h3000_0006, ALL, "R4 ber ch3");
      fid[5] = 32'h55; ber[5] = 1; step(); clr_ev();
      rd(3'd2, 32'h7000_0006, ALL, "R4 ber accumulate");
      rd(3'd4, 32'h55, ALL, "R9 ber capture again");
      irq_is(1'b0, "R5 ber not a line source");
      // R10 clear of bit 2 also clears the channel field
      wr(3'd2, 32'h4); rd(3'd2, 32'h2, ALL, "R10 clear ber field");
      wr(3'd2, 32'h2); rd(3'd2, 0, ALL, "R10 clear sof0");
      // unmask all, enable stays set
      wr(3'd0, 32'h1); wr(3'd1, 32'h0);
      rd(3'd2, 0, 32'h80, "R12 no quick disable 1->1");
      // R7 / R3 / R5: two channels in one cycle
      fid[2] = 32'h22; fid[4] = 32'h44; sof[2] = 1; eof[4] = 1;
      step(); clr_ev();
      @(negedge clk); chk("R5 line lags one cycle", {31'h0, irq}, 32'h0); step();
      irq_is(1'b1, "R5 line rises");
      rd(3'd3, 32'h802, ALL, "R3 sof ch2 eof ch4");
      rd(3'd4, 32'h22, ALL, "R7 lowest channel wins");
      // R8 event with line high
      fid[0] = 32'h99; brs[0] = 1; step(); clr_ev();
      rd(3'd2, 32'h600, ALL, "R8 second interrupt");
      rd(3'd4, 32'h22, ALL, "R8 ident held");
      // R11 clear masks of status 1
      wr(3'd3, ALL); rd(3'd3, 0, ALL, "R11 clear stat1");
      brs[1] = 1; step(); clr_ev();
      rd(3'd3, 32'h1_0000, ALL, "R3 brs ch1");
      wr(3'd3, ALL); rd(3'd3, 32'h1_0000, ALL, "R11 brs ch1 kept");
      // R5 masking silences the line
      wr(3'd1, 32'h1_0000); wr(3'd2, 32'hFFF);
      step(); irq_is(1'b0, "R5 masked line low");
      // R12 quick disable
      wr(3'd0, 32'h0); rd(3'd2, 32'h80, ALL, "R12 quick disable");
      wr(3'd2, 32'h80); wr(3'd0, 32'h0);
      rd(3'd2, 0, ALL, "R12 no event 0->0");
      // R13 collisions
      done = 1; reg_wr = 1; reg_sel = 3'd2; reg_wdata = 32'h1; step(); reg_wr = 0; clr_ev();
      rd(3'd2, 32'h1, ALL, "R13 set beats clear");
      ber[6] = 1; reg_wr = 1; reg_sel = 3'd2; reg_wdata = 32'h5; step(); reg_wr = 0; clr_ev();
      rd(3'd2, 32'h6000_0004, 32'h7000_0005, "R13 ber beats clear");
      // R2 global event positions
      wr(3'd2, ALL);
      acb = 1; und = 2'b11; outund = 1; rdst = 1; cmd = 1; eof[0] = 1;
      step(); clr_ev();
      rd(3'd2, 32'h1978, 32'h1978, "R2 global bits");
      wr(3'd2, 32'hFFF); rd(3'd2, 32'h1000, ALL, "R10 bit 12 sticky");
      // random phase, compared each clock
      for (int i = 0; i < 3000; i++) begin
         sof = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
         eof = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
         brs = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
         ber = NCH'($urandom) & NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
         done = ($urandom % 16) == 0; acb = ($urandom % 16) == 0;
         und = 2'($urandom) & 2'($urandom); outund = ($urandom % 16) == 0;
         rdst = ($urandom % 16) == 0; cmd = ($urandom % 64) == 0;
         for (int c = 0; c < NCH; c++) fid[c] = $urandom;
         reg_sel = 3'($urandom % 6);
         reg_wr = ($urandom % 4) == 0;
         reg_wdata = ($urandom % 2) ? $urandom : ALL;
         step();
      end
      reg_wr = 0; clr_ev();
      repeat (4) step();
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #400000;
      if (!done_flag) begin
         n_bad++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule